// File: doc/BRIEF.md
# Coprocessor Transfer Address Sequencer

This block drives the memory side of a multi-word coprocessor load or store. It accepts the decoded fields of one such instruction: a word-count immediate, the add/subtract, index-before/index-after and update-base bits, and the base register number. Along with them it takes the base register contents and the address of the instruction itself. From these it produces one address and one transfer strobe for each word, a cycle-type tag on every cycle, and at the end a base-update value with its enable.

The coprocessor paces the sequence with two signals. A busy signal holds off the first transfer. A last-word signal, given together with a transfer, ends the run. The memory can abort any transfer. The sequence then stops, but the base update still happens, so the instruction can be retried once the cause of the abort is handled.

The block holds one instruction at a time. It accepts a new one only while idle, and it pulses done in the closing cycle of each instruction.

Top module: `cp_xfer_seq`

## Requirements
- R1: `ready` is high only in the idle state. `start` is accepted only while `ready` is high. While an instruction is in progress, `start` and all field inputs have no effect.
- R2: The offset is `imm_ofs` times 4, zero-extended. When `up`=1 it is added to the base, and when `up`=0 it is subtracted. The arithmetic wraps modulo 2^32.
- R3: When `pre`=1 the first transfer address is the modified base. When `pre`=0 it is the unmodified base.
- R4: Each transfer after the first has an address exactly 4 above the previous one. The base is never aligned: its bits [1:0] appear unchanged on `addr`.
- R5: When `base_idx`=15, the base used is `instr_addr`+8 and `base_val` is ignored.
- R6: `wb_en` pulses in the closing cycle only if `wb_req`=1 and `base_idx`≠15. `wb_value` then carries the modified base. This applies in both pre and post modes.
- R7: When `wb_req`=1 and `base_idx`=15, `wb_illegal` pulses in the closing cycle and `wb_en` stays low.
- R8: While `cp_busy` is high before the first transfer, the block emits internal cycles with no strobe and `addr` held stable. The first transfer comes in the first cycle with `cp_busy` low. After that, `cp_busy` is ignored.
- R9: `cp_last` high during a strobe makes that word the last one. The cycle tags are: `cyc_type` 00 = none (idle), 01 = internal, 10 = sequential, 11 = non-sequential. The first transfer is non-sequential, each later transfer is sequential, and the closing cycle is non-sequential. So n words with b busy cycles take b internal, n-1 sequential and 2 non-sequential cycles.
- R10: `mem_abort` high during a strobe ends the sequence after that word. `data_abort` then pulses in the closing cycle, and the base update of R6 still takes place. When abort and last word arrive together, the abort is reported.
- R11: `done` is high for exactly the one closing cycle after the last word or the aborted word. The block is ready again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction valid |
| ready | output | 1 | Idle, can accept an instruction |
| imm_ofs | input | 8 | Unsigned word offset |
| up | input | 1 | 1 adds the offset, 0 subtracts it |
| pre | input | 1 | 1 applies the offset before the first transfer |
| wb_req | input | 1 | Request the base update |
| base_idx | input | 4 | Base register number |
| base_val | input | 32 | Base register contents |
| instr_addr | input | 32 | Address of the instruction |
| cp_busy | input | 1 | Coprocessor not ready for the first word |
| cp_last | input | 1 | The current word is the last one |
| mem_abort | input | 1 | Memory aborts the current transfer |
| addr | output | 32 | Transfer address |
| xfer | output | 1 | Transfer strobe, one per word |
| cyc_type | output | 2 | Cycle tag: 00 none, 01 internal, 10 sequential, 11 non-sequential |
| wb_en | output | 1 | Base update enable |
| wb_value | output | 32 | Updated base value |
| wb_illegal | output | 1 | Update requested on register 15 |
| data_abort | output | 1 | Sequence ended by an abort |
| done | output | 1 | Closing cycle of the instruction |

## Verification
The memory abort and the coprocessor's last-word signal can both arrive on the same transfer. Each of them alone ends the run, and they disagree on how the end is reported. The bench provokes the collision by raising both on one strobe, once with a base update requested and once without. Its cycle-level model expects a single closing cycle in which done and data_abort both pulse and the base update follows R6. It also expects no further strobe and the cycle totals of an aborted run.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  typedef enum logic [1:0] {
    CYC_NONE = 2'b00,
    CYC_INT  = 2'b01,
    CYC_SEQ  = 2'b10,
    CYC_NSEQ = 2'b11
  } cyc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_XFER = 2'b01,
    ST_FIN  = 2'b10
  } seq_st_e;
endpackage

// File: rtl/cpx_addr_calc.sv
module cpx_addr_calc #(
  parameter int AW       = 32,
  parameter int OW       = 8,
  parameter int SH       = 2,
  parameter int RW       = 4,
  parameter int PC_IDX   = 15,
  parameter int PC_AHEAD = 8
) (
  input  logic [OW-1:0] imm_ofs,
  input  logic          up,
  input  logic          pre,
  input  logic [RW-1:0] base_idx,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] instr_addr,
  output logic [AW-1:0] first_addr,
  output logic [AW-1:0] mod_base,
  output logic          base_is_pc
);
  function automatic logic [AW-1:0] scale_ofs(input logic [OW-1:0] imm);
    return AW'({imm, {SH{1'b0}}});
  endfunction

  function automatic logic [AW-1:0] step_base(input logic [AW-1:0] b,
                                               input logic [AW-1:0] o,
                                               input logic         add);
    return add ? (b + o) : (b - o);
  endfunction

  logic [AW-1:0] eff_base;

  always_comb begin
    base_is_pc = (base_idx == RW'(PC_IDX));
    eff_base   = base_is_pc ? (instr_addr + AW'(PC_AHEAD)) : base_val;
    mod_base   = step_base(eff_base, scale_ofs(imm_ofs), up);
    first_addr = pre ? mod_base : eff_base;
  end
endmodule

// File: rtl/cpx_addr_ctr.sv
module cpx_addr_ctr #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= addr + AW'(STEP);
  end
endmodule

// File: rtl/cpx_seq_ctrl.sv
module cpx_seq_ctrl
  import cpx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cp_busy,
  input  logic       cp_last,
  input  logic       mem_abort,
  output logic       ready,
  output logic       load,
  output logic       strobe,
  output logic       fin,
  output logic       aborted,
  output logic [1:0] cyc_type
);
  seq_st_e st_q;
  logic    first_q;
  logic    abort_q;
  logic    hold;

  always_comb begin
    ready    = (st_q == ST_IDLE);
    load     = ready && start;
    hold     = first_q && cp_busy;
    strobe   = (st_q == ST_XFER) && !hold;
    fin      = (st_q == ST_FIN);
    aborted  = abort_q;
    cyc_type = CYC_NONE;
    unique case (st_q)
      ST_XFER: cyc_type = hold ? CYC_INT : (first_q ? CYC_NSEQ : CYC_SEQ);
      ST_FIN:  cyc_type = CYC_NSEQ;
      default: cyc_type = CYC_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      first_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q    <= ST_XFER;
          first_q <= 1'b1;
          abort_q <= 1'b0;
        end
        ST_XFER: if (strobe) begin
          first_q <= 1'b0;
          if (mem_abort) begin
            abort_q <= 1'b1;
            st_q    <= ST_FIN;
          end else if (cp_last) begin
            st_q <= ST_FIN;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cp_xfer_seq.sv
module cp_xfer_seq #(
  parameter int AW       = 32,
  parameter int OW       = 8,
  parameter int RW       = 4,
  parameter int WORD_B   = 4,
  parameter int PC_IDX   = 15,
  parameter int PC_AHEAD = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          ready,
  input  logic [OW-1:0] imm_ofs,
  input  logic          up,
  input  logic          pre,
  input  logic          wb_req,
  input  logic [RW-1:0] base_idx,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] instr_addr,
  input  logic          cp_busy,
  input  logic          cp_last,
  input  logic          mem_abort,
  output logic [AW-1:0] addr,
  output logic          xfer,
  output logic [1:0]    cyc_type,
  output logic          wb_en,
  output logic [AW-1:0] wb_value,
  output logic          wb_illegal,
  output logic          data_abort,
  output logic          done
);
  localparam int SH = $clog2(WORD_B);

  logic [AW-1:0] first_addr, mod_base, mod_q;
  logic          base_is_pc, pc_q, wb_q;
  logic          load, fin, aborted;

  cpx_addr_calc #(
    .AW(AW), .OW(OW), .SH(SH), .RW(RW), .PC_IDX(PC_IDX), .PC_AHEAD(PC_AHEAD)
  ) u_calc (
    .imm_ofs(imm_ofs), .up(up), .pre(pre), .base_idx(base_idx),
    .base_val(base_val), .instr_addr(instr_addr),
    .first_addr(first_addr), .mod_base(mod_base), .base_is_pc(base_is_pc)
  );

  cpx_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cp_busy(cp_busy),
    .cp_last(cp_last), .mem_abort(mem_abort), .ready(ready), .load(load),
    .strobe(xfer), .fin(fin), .aborted(aborted), .cyc_type(cyc_type)
  );

  cpx_addr_ctr #(.AW(AW), .STEP(WORD_B)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(first_addr),
    .step(xfer), .addr(addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mod_q <= '0;
      pc_q  <= 1'b0;
      wb_q  <= 1'b0;
    end else if (load) begin
      mod_q <= mod_base;
      pc_q  <= base_is_pc;
      wb_q  <= wb_req;
    end
  end

  always_comb begin
    done       = fin;
    wb_value   = mod_q;
    wb_en      = fin && wb_q && !pc_q;
    wb_illegal = fin && wb_q && pc_q;
    data_abort = fin && aborted;
  end
endmodule

// File: rtl/cpx_checker.sv
module cpx_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          xfer,
  input logic [1:0]    cyc_type,
  input logic [AW-1:0] addr,
  input logic          cp_last,
  input logic          mem_abort,
  input logic          wb_en,
  input logic          wb_illegal,
  input logic          data_abort,
  input logic          done
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!xfer && cyc_type == 2'b00 && !done));

  assert_word_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !cp_last && !mem_abort) |=> (xfer && addr == $past(addr) + AW'(4)));

  assert_wb_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  assert_illegal_blocks_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_illegal |-> (!wb_en && done));

  assert_wait_holds_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 2'b01) |=> $stable(addr));

  assert_wait_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 2'b01) |-> !xfer);

  assert_last_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cp_last) |=> (done && !xfer && cyc_type == 2'b11));

  assert_abort_reported_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && mem_abort) |=> (done && data_abort && !xfer));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && ready));
endmodule

bind cp_xfer_seq cpx_checker #(.AW(AW)) u_cpx_checker (
  .clk(clk), .rst_n(rst_n), .ready(ready), .xfer(xfer), .cyc_type(cyc_type),
  .addr(addr), .cp_last(cp_last), .mem_abort(mem_abort), .wb_en(wb_en),
  .wb_illegal(wb_illegal), .data_abort(data_abort), .done(done)
);

// File: tb/test_cp_xfer_seq.sv
module test_cp_xfer_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, up = 1'b0, pre = 1'b0, wb_req = 1'b0;
  logic [7:0]  imm_ofs = '0;
  logic [3:0]  base_idx = '0;
  logic [31:0] base_val = '0, instr_addr = '0;
  logic        cp_busy = 1'b0, cp_last = 1'b0, mem_abort = 1'b0;
  logic        ready, xfer, wb_en, wb_illegal, data_abort, done;
  logic [1:0]  cyc_type;
  logic [31:0] addr, wb_value;

  int total = 0, bad = 0, ncyc = 0;
  bit finished = 0;

  // behavioural reference state
  int          m_ph = 0;
  bit          m_first = 0, m_wb = 0, m_pc = 0, m_ab = 0;
  logic [31:0] m_addr = '0, m_wbv = '0;
  int          cnt_i = 0, cnt_s = 0, cnt_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cp_xfer_seq i_cp_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .imm_ofs(imm_ofs),
    .up(up), .pre(pre), .wb_req(wb_req), .base_idx(base_idx),
    .base_val(base_val), .instr_addr(instr_addr), .cp_busy(cp_busy),
    .cp_last(cp_last), .mem_abort(mem_abort), .addr(addr), .xfer(xfer),
    .cyc_type(cyc_type), .wb_en(wb_en), .wb_value(wb_value),
    .wb_illegal(wb_illegal), .data_abort(data_abort), .done(done)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h (t=%0t)", req, what, got, exp, $time);
    end
  endtask

  // one clock: compare outputs against the model, then advance the model
  task automatic tick();
    bit e_strobe;
    logic [1:0] e_cyc;
    longint ofs, eb, mb;
    #1;
    e_strobe = (m_ph == 1) && !(m_first && cp_busy);
    if (m_ph == 0)      e_cyc = 2'b00;
    else if (m_ph == 2) e_cyc = 2'b11;
    else if (!e_strobe) e_cyc = 2'b01;
    else                e_cyc = m_first ? 2'b11 : 2'b10;
    check("R1", "ready", 32'(ready), 32'(m_ph == 0));
    check("R8", "xfer", 32'(xfer), 32'(e_strobe));
    check("R9", "cyc_type", 32'(cyc_type), 32'(e_cyc));
    if (m_ph == 1) check(m_first ? "R3" : "R4", "addr", addr, m_addr);
    check("R11", "done", 32'(done), 32'(m_ph == 2));
    check("R6", "wb_en", 32'(wb_en), 32'(m_ph == 2 && m_wb && !m_pc));
    if (m_ph == 2 && m_wb && !m_pc) check("R6", "wb_value", wb_value, m_wbv);
    check("R7", "wb_illegal", 32'(wb_illegal), 32'(m_ph == 2 && m_wb && m_pc));
    check("R10", "data_abort", 32'(data_abort), 32'(m_ph == 2 && m_ab));
    case (e_cyc)
      2'b01: cnt_i++;
      2'b10: cnt_s++;
      2'b11: cnt_n++;
      default: ;
    endcase
    @(posedge clk);
    case (m_ph)
      0: if (start && rst_n) begin
        eb  = (base_idx == 4'd15) ? (longint'(instr_addr) + 8) : longint'(base_val);
        ofs = longint'(imm_ofs) * 4;
        mb  = up ? eb + ofs : eb - ofs;
        m_wbv = mb[31:0];
        m_addr = pre ? mb[31:0] : eb[31:0];
        m_wb = wb_req; m_pc = (base_idx == 4'd15);
        m_first = 1; m_ab = 0; m_ph = 1;
      end
      1: if (e_strobe) begin
        m_first = 0;
        m_addr = m_addr + 32'd4;
        if (mem_abort) begin m_ab = 1; m_ph = 2; end
        else if (cp_last) m_ph = 2;
      end
      default: m_ph = 0;
    endcase
    @(negedge clk);
  endtask

  // one instruction: b busy cycles, n words, abort on word k (-1 none)
  task automatic run(input logic [7:0] imm, input bit u, input bit p, input bit w,
                     input logic [3:0] rn, input logic [31:0] bv, input logic [31:0] pc,
                     input int b, input int n, input int k, input bit noisy);
    int moved;
    imm_ofs = imm; up = u; pre = p; wb_req = w; base_idx = rn;
    base_val = bv; instr_addr = pc; start = 1;
    tick();
    cnt_i = 0; cnt_s = 0; cnt_n = 0;
    if (!noisy) start = 0;
    else begin   // R1: fields change while busy, start held high
      base_val = ~bv; imm_ofs = ~imm; up = ~u; pre = ~p; wb_req = ~w; base_idx = ~rn;
    end
    for (int j = 0; j < b; j++) begin
      cp_busy = 1; cp_last = (j == 0); mem_abort = (j == 0);   // R8: ignored while waiting
      tick();
    end
    moved = 0;
    for (int j = 0; j < n; j++) begin
      cp_busy = (j > 0);           // R8: busy ignored after the first word
      cp_last = (j == n - 1);
      mem_abort = (j == k);
      tick();
      moved++;
      if (j == k) break;
    end
    cp_busy = 0; cp_last = 0; mem_abort = 0;
    if (noisy) start = 0;
    tick();                        // closing cycle
    check("R9", "internal cycles", 32'(cnt_i), 32'(b));
    check("R9", "sequential cycles", 32'(cnt_s), 32'(moved - 1));
    check("R9", "non-sequential cycles", 32'(cnt_n), 32'd2);
    start = 0;
    tick();                        // R11: back to idle
    check("R11", "ready after done", 32'(ready), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset ready", 32'(ready), 32'd1);
    check("R11", "reset done", 32'(done), 32'd0);
    check("R9", "reset cyc_type", 32'(cyc_type), 32'd0);
    rst_n = 1;
    @(negedge clk);
    tick();
    // R2 R3: pre, add, write-back
    run(8'd3, 1, 1, 1, 4'd2, 32'h0000_1000, 32'h0, 2, 4, -1, 0);
    // R2 R3: post, subtract, no write-back
    run(8'd5, 0, 0, 0, 4'd7, 32'h0000_2000, 32'h0, 0, 3, -1, 0);
    // R6: post-indexed write-back only when requested
    run(8'd1, 1, 0, 1, 4'd0, 32'h0000_0100, 32'h0, 1, 1, -1, 0);
    // R5: base register 15 uses instruction address plus 8
    run(8'd2, 1, 1, 0, 4'd15, 32'hDEAD_BEEF, 32'h0000_3000, 0, 2, -1, 0);
    // R7: write-back on register 15 is illegal
    run(8'd4, 0, 0, 1, 4'd15, 32'h0, 32'h0000_4000, 1, 3, -1, 0);
    // R4: unaligned base keeps its low bits
    run(8'd0, 1, 1, 0, 4'd3, 32'h0000_1003, 32'h0, 0, 3, -1, 0);
    // R10: abort on the second of four words with write-back
    run(8'd6, 1, 1, 1, 4'd1, 32'h0000_5000, 32'h0, 1, 4, 1, 0);
    // R10: abort and last word on the same transfer
    run(8'd2, 0, 1, 1, 4'd5, 32'h0000_6000, 32'h0, 0, 2, 1, 0);
    run(8'd2, 1, 0, 0, 4'd5, 32'h0000_6000, 32'h0, 2, 1, 0, 0);
    // R2: subtraction wraps, largest offset
    run(8'hFF, 0, 1, 1, 4'd9, 32'h0000_0004, 32'h0, 0, 2, -1, 0);
    run(8'hFF, 1, 1, 1, 4'd9, 32'hFFFF_FF00, 32'h0, 0, 2, -1, 0);
    // R1: start and fields changing during a run are ignored
    run(8'd1, 1, 1, 1, 4'd4, 32'h0000_7000, 32'h0, 2, 3, -1, 1);
    repeat (2) tick();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (!finished) begin
      @(posedge clk);
      ncyc++;
      if (ncyc > 100000 && !finished) begin
        total++; bad++;
        $display("FAIL watchdog: got %0d cycles expected fewer", ncyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule